// File: doc/BRIEF.md
# Instruction Fetch and Branch Unit

This block owns the program counter of a small Harvard-style core whose program store is a separate 512-byte memory. Every instruction is 16 bits and occupies two consecutive bytes. The counter indexes whole instructions, not bytes. From the counter the block forms the two byte addresses of the current instruction. It joins the two bytes that the program store returns into one little-endian instruction word, and it chooses the counter value for the next cycle.

The next value comes from the decoded branch kind. Without a branch the counter advances by one. There is a plain jump and a jump-and-link, which also hands the return index to the register file. The fourth kind is a conditional branch: one of ten tests on the carry, sign and zero flags decides between the target and the next sequential index. The program store is read combinationally outside the block. Instruction decode and the arithmetic unit are separate.

Top module: `ifu_fetch_branch`

## Requirements
- R1: While reset is asserted, and at once when `rst_n` falls (asynchronously), `pc` is 0 and `link_we` is 0. Release of reset takes effect synchronously.
- R2: `rom_addr_lo` equals 2·`pc` and `rom_addr_hi` equals 2·`pc`+1, combinationally.
- R3: `instr` equals {`rom_data_hi`, `rom_data_lo`}. The byte at the lower address is bits 7:0, which is little-endian order.
- R4: With `step_en`=1 and `br_kind`=2'b00 (sequential), `pc` becomes `pc`+1 at the next rising edge, and 255 wraps to 0.
- R5: With `step_en`=1 and `br_kind`=2'b01 (jump), `pc` becomes `br_target` at the next edge.
- R6: With `step_en`=1 and `br_kind`=2'b10 (jump-and-link), `link_we` is 1 and `link_val` equals `pc`+1 (mod 256) in the same cycle, and `pc` becomes `br_target` at the next edge. In all other cases `link_we` is 0.
- R7: With `step_en`=1 and `br_kind`=2'b11 (conditional), `pc` becomes `br_target` if the test chosen by `cond_sel` holds, and `pc`+1 otherwise. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 C&!Z (unsigned greater, strict); 5 !C|Z; 6 S; 7 !S; 8 !S&!Z; 9 S|Z. C=1 means no borrow on compare.
- R8: With `br_kind`=2'b11, the codes 10 to 15 never take the branch, and `pc` advances by one.
- R9: With `step_en`=0, `pc` holds its value and `link_we` is 0, whatever the branch inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance enable for the counter |
| br_kind | input | 2 | 00 sequential, 01 jump, 10 jump-and-link, 11 conditional |
| cond_sel | input | 4 | Condition code for conditional branches |
| flag_c | input | 1 | Carry flag (1 = no borrow) |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| br_target | input | 8 | Target instruction index |
| rom_addr_lo | output | 9 | Byte address of the low instruction byte |
| rom_addr_hi | output | 9 | Byte address of the high instruction byte |
| rom_data_lo | input | 8 | Program byte read at rom_addr_lo |
| rom_data_hi | input | 8 | Program byte read at rom_addr_hi |
| instr | output | 16 | Assembled instruction word |
| pc | output | 8 | Current instruction index |
| link_val | output | 8 | Return index for jump-and-link |
| link_we | output | 1 | Link register write strobe |

## Verification
The byte addresses, the instruction word and the link strobe with its value depend only on the current counter and the inputs, so they are due in the same cycle as the stimulus. The bench drives inputs after a falling edge and samples these outputs one time unit later. The counter has one register, so a branch decision shows at `pc` one rising edge later. The bench checks it one time unit after that edge, against an index it tracks itself from the table's expected taken bit. The asynchronous clear is checked one time unit after `rst_n` falls, with no clock edge in between.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    BK_SEQ  = 2'b00,
    BK_JUMP = 2'b01,
    BK_LINK = 2'b10,
    BK_COND = 2'b11
  } br_kind_e;

  typedef enum logic [3:0] {
    CC_ZSET  = 4'd0,
    CC_ZCLR  = 4'd1,
    CC_CSET  = 4'd2,
    CC_CCLR  = 4'd3,
    CC_UGTS  = 4'd4,
    CC_ULE   = 4'd5,
    CC_NEG   = 4'd6,
    CC_POS   = 4'd7,
    CC_SGT0  = 4'd8,
    CC_SLE0  = 4'd9
  } cond_e;

  localparam int unsigned NUM_CONDS = 10;

endpackage

// File: rtl/ifu_cond_eval.sv
module ifu_cond_eval
  import ifu_pkg::*;
(
  input  logic [3:0] code,
  input  logic       c_in,
  input  logic       s_in,
  input  logic       z_in,
  output logic       hit
);

  always_comb begin
    hit = 1'b0;
    if (code < 4'(NUM_CONDS)) begin
      unique case (cond_e'(code))
        CC_ZSET: hit = z_in;
        CC_ZCLR: hit = !z_in;
        CC_CSET: hit = c_in;
        CC_CCLR: hit = !c_in;
        CC_UGTS: hit = c_in && !z_in;
        CC_ULE:  hit = !c_in || z_in;
        CC_NEG:  hit = s_in;
        CC_POS:  hit = !s_in;
        CC_SGT0: hit = !s_in && !z_in;
        CC_SLE0: hit = s_in || z_in;
        default: hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ifu_pc_sel.sv
module ifu_pc_sel
  import ifu_pkg::*;
#(
  parameter int unsigned PC_W = 8
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic [1:0]      kind,
  input  logic            cond_hit,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] next_pc,
  output logic            want_link,
  output logic [PC_W-1:0] ret_idx
);

  logic [PC_W-1:0] seq_pc;
  logic            redirect;

  assign seq_pc = cur_pc + PC_W'(1);

  always_comb begin
    redirect  = 1'b0;
    want_link = 1'b0;
    unique case (br_kind_e'(kind))
      BK_SEQ:  redirect = 1'b0;
      BK_JUMP: redirect = 1'b1;
      BK_LINK: begin
        redirect  = 1'b1;
        want_link = 1'b1;
      end
      BK_COND: redirect = cond_hit;
      default: redirect = 1'b0;
    endcase
    next_pc = redirect ? target : seq_pc;
  end

  assign ret_idx = seq_pc;

endmodule

// File: rtl/ifu_byte_join.sv
module ifu_byte_join #(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned ADDR_W = PC_W + SEL_W
) (
  input  logic [PC_W-1:0]          idx,
  output logic [NBYTES*ADDR_W-1:0] byte_addr,
  input  logic [NBYTES*BYTE_W-1:0] byte_data,
  output logic [NBYTES*BYTE_W-1:0] word
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    // byte g of the word sits at the g-th address above the base: little-endian
    assign byte_addr[g*ADDR_W +: ADDR_W] = {idx, SEL_W'(g)};
    assign word[g*BYTE_W +: BYTE_W]      = byte_data[g*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/ifu_fetch_branch.sv
module ifu_fetch_branch
  import ifu_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = PC_W + 1,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        br_kind,
  input  logic [3:0]        cond_sel,
  input  logic              flag_c,
  input  logic              flag_s,
  input  logic              flag_z,
  input  logic [PC_W-1:0]   br_target,
  output logic [ADDR_W-1:0] rom_addr_lo,
  output logic [ADDR_W-1:0] rom_addr_hi,
  input  logic [BYTE_W-1:0] rom_data_lo,
  input  logic [BYTE_W-1:0] rom_data_hi,
  output logic [WORD_W-1:0] instr,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   link_val,
  output logic              link_we
);

  localparam int unsigned NBYTES = 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [PC_W-1:0] pc_q, pc_d;
  logic            cond_hit, want_link;
  logic [PC_W-1:0] ret_idx;
  logic [NBYTES*ADDR_W-1:0] addr_bus;

  ifu_cond_eval u_cond (
    .code  (cond_sel),
    .c_in  (flag_c),
    .s_in  (flag_s),
    .z_in  (flag_z),
    .hit   (cond_hit)
  );

  ifu_pc_sel #(.PC_W(PC_W)) u_sel (
    .cur_pc    (pc_q),
    .kind      (br_kind),
    .cond_hit  (cond_hit),
    .target    (br_target),
    .next_pc   (pc_d),
    .want_link (want_link),
    .ret_idx   (ret_idx)
  );

  ifu_byte_join #(.PC_W(PC_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_join (
    .idx       (pc_q),
    .byte_addr (addr_bus),
    .byte_data ({rom_data_hi, rom_data_lo}),
    .word      (instr)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (step_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc          = pc_q;
  assign rom_addr_lo = addr_bus[0 +: ADDR_W];
  assign rom_addr_hi = addr_bus[ADDR_W +: ADDR_W];
  assign link_val    = ret_idx;
  assign link_we     = step_en && want_link && rst_sync_n;

  // R2
  addr_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rom_addr_hi == rom_addr_lo + ADDR_W'(1)) && (rom_addr_lo[ADDR_W-1:1] == pc));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && br_kind == BK_SEQ) |=> (pc == $past(pc) + PC_W'(1)));

  // R5
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && br_kind == BK_JUMP) |=> (pc == $past(br_target)));

  // R6
  link_target_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_we |=> (pc == $past(br_target)));

  // R7
  cond_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && br_kind == BK_COND && !cond_hit) |=> (pc == $past(pc) + PC_W'(1)));

  // R8
  cond_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && br_kind == BK_COND && cond_sel >= 4'(NUM_CONDS))
      |=> (pc == $past(pc) + PC_W'(1)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_en |=> $stable(pc));

  // R9
  hold_nolink_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_en |-> !link_we);

endmodule

// File: tb/test_ifu_fetch_branch.sv
module test_ifu_fetch_branch;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic [1:0] br_kind;
  logic [3:0] cond_sel;
  logic       flag_c, flag_s, flag_z;
  logic [7:0] br_target;
  logic [8:0] rom_addr_lo, rom_addr_hi;
  logic [7:0] rom_data_lo, rom_data_hi;
  logic [15:0] instr;
  logic [7:0] pc, link_val;
  logic       link_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_pc;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [8:0] a);
    return (a[7:0] * 8'd13) ^ {a[8], 7'h25};
  endfunction

  assign rom_data_lo = rom_fn(rom_addr_lo);
  assign rom_data_hi = rom_fn(rom_addr_hi);

  ifu_fetch_branch i_ifu_fetch_branch (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .br_kind(br_kind),
    .cond_sel(cond_sel), .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
    .br_target(br_target), .rom_addr_lo(rom_addr_lo), .rom_addr_hi(rom_addr_hi),
    .rom_data_lo(rom_data_lo), .rom_data_hi(rom_data_hi), .instr(instr),
    .pc(pc), .link_val(link_val), .link_we(link_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {kind[1:0], cond[3:0], {c,s,z}, target[7:0], expected taken}
  localparam int NV = 26;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 4'd0, 3'b000, 8'h00, 1'b0},
    {2'd1, 4'd0, 3'b000, 8'h20, 1'b1},
    {2'd2, 4'd0, 3'b000, 8'h7E, 1'b1},
    {2'd3, 4'd0, 3'b001, 8'h10, 1'b1},
    {2'd3, 4'd0, 3'b000, 8'h11, 1'b0},
    {2'd3, 4'd1, 3'b000, 8'h12, 1'b1},
    {2'd3, 4'd1, 3'b001, 8'h13, 1'b0},
    {2'd3, 4'd2, 3'b100, 8'h14, 1'b1},
    {2'd3, 4'd2, 3'b011, 8'h15, 1'b0},
    {2'd3, 4'd3, 3'b000, 8'h16, 1'b1},
    {2'd3, 4'd4, 3'b100, 8'h17, 1'b1},
    {2'd3, 4'd4, 3'b101, 8'h18, 1'b0},
    {2'd3, 4'd4, 3'b000, 8'h19, 1'b0},
    {2'd3, 4'd5, 3'b000, 8'h1A, 1'b1},
    {2'd3, 4'd5, 3'b101, 8'h1B, 1'b1},
    {2'd3, 4'd5, 3'b100, 8'h1C, 1'b0},
    {2'd3, 4'd6, 3'b010, 8'h1D, 1'b1},
    {2'd3, 4'd7, 3'b010, 8'h1E, 1'b0},
    {2'd3, 4'd7, 3'b100, 8'h1F, 1'b1},
    {2'd3, 4'd8, 3'b000, 8'h30, 1'b1},
    {2'd3, 4'd8, 3'b001, 8'h31, 1'b0},
    {2'd3, 4'd9, 3'b010, 8'h32, 1'b1},
    {2'd3, 4'd9, 3'b000, 8'h33, 1'b0},
    {2'd3, 4'd10, 3'b111, 8'h34, 1'b0},
    {2'd3, 4'd15, 3'b000, 8'h35, 1'b0},
    {2'd2, 4'd0, 3'b000, 8'hC0, 1'b1}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; br_kind = 2'b00; cond_sel = 4'd0;
    flag_c = 1'b0; flag_s = 1'b0; flag_z = 1'b0; br_target = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pc in reset", 32'(pc), 32'h0);
    chk("R1 link_we in reset", 32'(link_we), 32'h0);
    chk("R2 addr lo", 32'(rom_addr_lo), 32'h0);
    chk("R2 addr hi", 32'(rom_addr_hi), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    exp_pc = 8'h00;

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      br_kind = v[17:16]; cond_sel = v[15:12];
      {flag_c, flag_s, flag_z} = v[11:9];
      br_target = v[8:1]; step_en = 1'b1;
      #1;
      chk("R2 addr lo", 32'(rom_addr_lo), 32'({exp_pc, 1'b0}));
      chk("R2 addr hi", 32'(rom_addr_hi), 32'({exp_pc, 1'b1}));
      chk("R3 instr", 32'(instr),
          32'({rom_fn({exp_pc, 1'b1}), rom_fn({exp_pc, 1'b0})}));
      chk("R6 link_we", 32'(link_we), 32'(v[17:16] == 2'd2));
      if (v[17:16] == 2'd2) chk("R6 link_val", 32'(link_val), 32'(8'(exp_pc + 8'd1)));
      @(posedge clk);
      #1;
      exp_pc = v[0] ? v[8:1] : 8'(exp_pc + 8'd1);
      case (v[17:16])
        2'd0: tag = "R4 next pc";
        2'd1: tag = "R5 next pc";
        2'd2: tag = "R6 next pc";
        default: tag = (v[15:12] > 4'd9) ? "R8 next pc" : "R7 next pc";
      endcase
      chk(tag, 32'(pc), 32'(exp_pc));
    end

    // R9: hold with link request
    @(negedge clk);
    step_en = 1'b0; br_kind = 2'b10; br_target = 8'h33;
    #1;
    chk("R9 link_we held", 32'(link_we), 32'h0);
    @(posedge clk); #1;
    chk("R9 pc held", 32'(pc), 32'(exp_pc));

    // R4: wrap 255 -> 0
    @(negedge clk);
    step_en = 1'b1; br_kind = 2'b01; br_target = 8'hFF;
    @(posedge clk); #1;
    chk("R5 jump to FF", 32'(pc), 32'hFF);
    @(negedge clk);
    br_kind = 2'b10; br_target = 8'h05;
    #1;
    chk("R6 link_val wrap", 32'(link_val), 32'h00);
    chk("R2 addr hi top", 32'(rom_addr_hi), 32'h1FF);
    @(negedge clk);
    br_kind = 2'b01; br_target = 8'hFF;
    @(posedge clk); #1;
    @(negedge clk);
    br_kind = 2'b00;
    @(posedge clk); #1;
    chk("R4 wrap", 32'(pc), 32'h00);

    // R1: asynchronous clear mid-run
    @(negedge clk);
    br_kind = 2'b01; br_target = 8'h40;
    @(posedge clk); #1;
    chk("R5 jump 40", 32'(pc), 32'h40);
    @(negedge clk);
    br_kind = 2'b10;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async pc", 32'(pc), 32'h0);
    chk("R1 async link_we", 32'(link_we), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule